// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address stream for read and write bursts of a four-bank synchronous DRAM. A mode write picks the burst length and the ordering, sequential or interleaved. Each read or write command carries a start column and a 2-bit bank number. From the rising clock edge that accepts the command, the block presents one column address per cycle, together with the bank, a write flag, a valid strobe and a last-beat flag.

A burst can be cut short by a stop command. It can also be replaced by a new read or write command on any cycle, with no gap. A full-page burst walks the whole row and wraps around until it is stopped or replaced. A mode setting that asks for an interleaved full-page burst, or that uses an unused length code, is refused. The refusal raises a one-cycle error pulse and leaves the previous setting in force.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, `addr_valid`, `addr_last`, `bank_active` and `mode_err` are 0. The reset mode is length 1, sequential, so a read issued without a mode write gives a single beat with `addr_last` = 1.
- R2: Sequential ordering (`mode_ilv` = 0), length code 000/001/010/011 = 1/2/4/8 beats. Beat i carries the start column with its low log2(N) bits replaced by (start + i) mod N. The upper bits stay unchanged.
- R3: Interleaved ordering (`mode_ilv` = 1), length codes 000 to 011. Beat i carries the start column with its low log2(N) bits XORed with i.
- R4: Length code 111 with sequential ordering is a full-page burst. Beat i is (start + i) mod 512. The burst never raises `addr_last` and runs until a stop or a new command.
- R5: `addr_last` is 1 only on the final beat of a non-full-page burst. If no new command arrives, `addr_valid` is 0 on the next cycle.
- R6: A stop command (`cmd_op` = 11) sampled on an edge makes `addr_valid` 0 from that edge on.
- R7: A read (`cmd_op` = 01) or write (`cmd_op` = 10) sampled on an edge starts a new burst at that edge, even in the middle of a burst or on its last beat. On that edge the output shows the new start column and bank, with no idle cycle.
- R8: A mode write with length code 100, 101 or 110, or with interleave plus code 111, is rejected. `mode_err` is 1 for exactly the cycle after the write, and later bursts keep the previous mode.
- R9: Each beat carries the bank and the write flag of its command. `bank_active` is one-hot at bit `addr_bank` while `addr_valid` is 1, and all zero otherwise.
- R10: A burst uses the mode in force when its command is sampled. A mode write sampled on the same edge as a command applies only to later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_ilv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| mode_len | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=full page |
| cmd_op | input | 2 | 00 none, 01 read, 10 write, 11 stop |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 9 | Start column of the command |
| addr_valid | output | 1 | A column address is presented this cycle |
| addr_col | output | 9 | Column address of the current beat |
| addr_bank | output | 2 | Bank of the current beat |
| addr_write | output | 1 | Current beat belongs to a write |
| addr_last | output | 1 | Final beat of a non-full-page burst |
| bank_active | output | 4 | One-hot bank under burst |
| mode_err | output | 1 | One-cycle pulse after a rejected mode write |

## Verification
Two cases put two functions in the same cycle. In the first, a mode write and a read are driven together. The bench then checks that the burst runs at the old length and that the next read picks up the new length. In the second, a new command lands on the last beat of a running burst. The bench checks that the next cycle already shows beat 0 of the new burst with `addr_valid` still high, and that no stray `addr_last` or idle cycle appears.

// File: rtl/bag_pkg.sv
// Package: command and mode encodings shared by the burst sequencer.
// Assumes a 3-bit length code and a 2-bit command code.
package bag_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_STOP = 2'b11
    } bag_op_e;

    localparam logic [2:0] LEN_FULL = 3'b111;

    typedef struct packed {
        logic       ilv;
        logic [2:0] len;
    } bag_mode_t;

    // True when a length code names a supported burst length.
    function automatic logic len_code_ok(input logic [2:0] code);
        return (code[2] == 1'b0) || (code == LEN_FULL);
    endfunction
endpackage

// File: rtl/bag_mode_reg.sv
// Module: holds the burst mode and refuses illegal settings.
// Assumes the writer holds mode_wr for one cycle per setting. A refused
// write leaves the stored mode unchanged and pulses err_q for one cycle.
module bag_mode_reg
    import bag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       ilv_in,
    input  logic [2:0] len_in,
    output bag_mode_t  mode_q,
    output logic       err_q
);
    logic accept;

    // Legality: a known length code, and full page only with sequential order.
    always_comb begin
        accept = len_code_ok(len_in) && !(ilv_in && (len_in == LEN_FULL));
    end

    // Store an accepted mode, or flag a refused one for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{ilv: 1'b0, len: 3'b000};
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (wr_en) begin
                if (accept) begin
                    mode_q <= '{ilv: ilv_in, len: len_in};
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bag_burst_ctrl.sv
// Module: burst state. Latches the command and its mode, counts beats,
// and ends a burst on its last beat, on a stop, or on a replacement.
// Assumes the mode input holds only legal settings (see bag_mode_reg).
module bag_burst_ctrl
    import bag_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  bag_mode_t         mode,
    output logic              active,
    output logic [COL_W-1:0]  beat,
    output logic [COL_W-1:0]  start,
    output logic [COL_W-1:0]  mask,
    output logic              ilv,
    output logic [BANK_W-1:0] bank,
    output logic              wr,
    output logic              last
);
    localparam int LG_W = $clog2(COL_W + 1);

    bag_op_e       op;
    logic [2:0]    lat_len;
    logic [LG_W-1:0] lg;
    logic [COL_W:0]  mask_w;
    logic          full;

    // Command decode.
    always_comb begin
        op = bag_op_e'(cmd_op);
    end

    // Latched length code -> log2 of the beat count and the wrap mask.
    always_comb begin
        case (lat_len)
            3'b000:  lg = LG_W'(0);
            3'b001:  lg = LG_W'(1);
            3'b010:  lg = LG_W'(2);
            3'b011:  lg = LG_W'(3);
            default: lg = LG_W'(COL_W);
        endcase
        full   = (lat_len == LEN_FULL);
        mask_w = ({{COL_W{1'b0}}, 1'b1} << lg) - {{COL_W{1'b0}}, 1'b1};
        mask   = mask_w[COL_W-1:0];
        last   = active && !full && (beat == mask);
    end

    // Burst sequencing: new command wins, then stop, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            beat    <= '0;
            start   <= '0;
            bank    <= '0;
            wr      <= 1'b0;
            lat_len <= 3'b000;
            ilv     <= 1'b0;
        end else begin
            case (op)
                OP_RD, OP_WR: begin
                    active  <= 1'b1;
                    beat    <= '0;
                    start   <= cmd_col;
                    bank    <= cmd_bank;
                    wr      <= (op == OP_WR);
                    lat_len <= mode.len;
                    ilv     <= mode.ilv;
                end
                OP_STOP: begin
                    active <= 1'b0;
                end
                default: begin
                    if (active) begin
                        if (last) begin
                            active <= 1'b0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bag_addr_map.sv
// Module: combinational column former. Applies the beat count to the
// start column inside the wrap mask, by addition or by XOR.
// Assumes the mask is of the form 2^k-1.
module bag_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    // Both orderings, then select by the latched type.
    always_comb begin
        seq_col = (start & ~mask) | ((start + beat) & mask);
        ilv_col = start ^ (beat & mask);
        col     = ilv ? ilv_col : seq_col;
    end
endmodule

// File: rtl/sdram_burst_addr_gen.sv
// Module: top of the burst column sequencer. Joins the mode register,
// the burst state and the column former, and decodes the bank one-hot.
// Assumes all inputs are synchronous to clk.
module sdram_burst_addr_gen
    import bag_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_wr,
    input  logic                     mode_ilv,
    input  logic [2:0]               mode_len,
    input  logic [1:0]               cmd_op,
    input  logic [BANK_W-1:0]        cmd_bank,
    input  logic [COL_W-1:0]         cmd_col,
    output logic                     addr_valid,
    output logic [COL_W-1:0]         addr_col,
    output logic [BANK_W-1:0]        addr_bank,
    output logic                     addr_write,
    output logic                     addr_last,
    output logic [(1<<BANK_W)-1:0]   bank_active,
    output logic                     mode_err
);
    localparam int NUM_BANKS = 1 << BANK_W;

    bag_mode_t        mode_q;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] start;
    logic [COL_W-1:0] mask;
    logic             ilv;

    bag_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .ilv_in (mode_ilv),
        .len_in (mode_len),
        .mode_q (mode_q),
        .err_q  (mode_err)
    );

    bag_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_op   (cmd_op),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .mode     (mode_q),
        .active   (addr_valid),
        .beat     (beat),
        .start    (start),
        .mask     (mask),
        .ilv      (ilv),
        .bank     (addr_bank),
        .wr       (addr_write),
        .last     (addr_last)
    );

    bag_addr_map #(.COL_W(COL_W)) u_map (
        .start (start),
        .beat  (beat),
        .mask  (mask),
        .ilv   (ilv),
        .col   (addr_col)
    );

    // One flag per bank: set while that bank's burst is running.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_active[b] = addr_valid && (addr_bank == BANK_W'(b));
    end
endmodule

// File: rtl/bag_checker.sv
// Module: protocol checks on the sequencer ports, bound to the top.
module bag_checker #(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode_wr,
    input logic [1:0]             cmd_op,
    input logic [BANK_W-1:0]      cmd_bank,
    input logic [COL_W-1:0]       cmd_col,
    input logic                   addr_valid,
    input logic [COL_W-1:0]       addr_col,
    input logic [BANK_W-1:0]      addr_bank,
    input logic                   addr_write,
    input logic                   addr_last,
    input logic [(1<<BANK_W)-1:0] bank_active,
    input logic                   mode_err
);
    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01 || cmd_op == 2'b10) |=> addr_valid && addr_col == $past(cmd_col) && addr_bank == $past(cmd_bank)); // R7
    AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b10) |=> addr_write); // R9
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b11) |=> !addr_valid); // R6
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_last && cmd_op == 2'b00) |=> !addr_valid); // R5
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid); // R5
    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_active) && (addr_valid == ($countones(bank_active) == 1))); // R9
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_last && cmd_op == 2'b00) |=> addr_valid && $stable(addr_bank) && $stable(addr_write)); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mode_wr)); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && cmd_op == 2'b00) |=> !addr_valid); // R1
endmodule

bind sdram_burst_addr_gen bag_checker #(.COL_W(COL_W), .BANK_W(BANK_W)) u_bag_chk (.*);

// File: tb/test_sdram_burst_addr_gen.sv
`timescale 1ns/1ps
module test_sdram_burst_addr_gen;
    localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, STP = 2'b11;
    localparam int NV = 9;
    // Fields: ilv[15] len[14:12] bank[11:10] wr[9] col[8:0]
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd0, 2'd1, 1'b0, 9'd5},
        {1'b0, 3'd1, 2'd2, 1'b1, 9'd11},
        {1'b0, 3'd2, 2'd3, 1'b0, 9'd30},
        {1'b0, 3'd3, 2'd0, 1'b1, 9'd13},
        {1'b1, 3'd1, 2'd1, 1'b0, 9'd3},
        {1'b1, 3'd2, 2'd2, 1'b1, 9'd10},
        {1'b1, 3'd3, 2'd3, 1'b0, 9'd21},
        {1'b1, 3'd0, 2'd0, 1'b1, 9'd511},
        {1'b0, 3'd3, 2'd2, 1'b0, 9'd511}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0, mode_ilv = 1'b0;
    logic [2:0] mode_len = 3'b000;
    logic [1:0] cmd_op = NOP, cmd_bank = 2'd0;
    logic [8:0] cmd_col = 9'd0;
    logic       addr_valid, addr_write, addr_last, mode_err;
    logic [8:0] addr_col;
    logic [1:0] addr_bank;
    logic [3:0] bank_active;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_burst_addr_gen i_sdram_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_ilv(mode_ilv),
        .mode_len(mode_len), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .addr_valid(addr_valid), .addr_col(addr_col), .addr_bank(addr_bank),
        .addr_write(addr_write), .addr_last(addr_last), .bank_active(bank_active),
        .mode_err(mode_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic mode_set(input logic ilv, input logic [2:0] len);
        mode_wr = 1'b1; mode_ilv = ilv; mode_len = len;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] bank, input logic [8:0] col);
        cmd_op = op; cmd_bank = bank; cmd_col = col;
        tick();
        cmd_op = NOP;
    endtask

    // Expected column from the ordering rules, by arithmetic.
    function automatic logic [8:0] exp_col(input logic ilv, input logic [2:0] len,
                                           input logic [8:0] s, input int i);
        int n, base, off;
        n = (len == 3'b111) ? 512 : (1 << len);
        if (ilv) return s ^ 9'(i % n);
        base = int'(s) - (int'(s) % n);
        off  = ((int'(s) % n) + i) % n;
        return 9'(base + off);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] e;
        int n;
        string rq;
        repeat (3) tick();
        chk("R1 valid in reset", 32'(addr_valid), 0);
        chk("R1 bank_active in reset", 32'(bank_active), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 valid after reset", 32'(addr_valid), 0);
        chk("R1 err after reset", 32'(mode_err), 0);
        chk("R1 last after reset", 32'(addr_last), 0);
        issue(RD, 2'd1, 9'd9);
        chk("R1 default single beat col", 32'(addr_col), 9);
        chk("R1 default single beat last", 32'(addr_last), 1);
        tick();
        chk("R1 default burst over", 32'(addr_valid), 0);

        // Table walk: R2 sequential, R3 interleaved, R9 bank/write carry.
        for (int v = 0; v < NV; v++) begin
            e = VEC[v];
            rq = e[15] ? "R3" : "R2";
            mode_set(e[15], e[14:12]);
            chk("R8 legal mode no err", 32'(mode_err), 0);
            issue(e[9] ? WR : RD, e[11:10], e[8:0]);
            n = 1 << e[14:12];
            for (int i = 0; i < n; i++) begin
                chk({rq, " col"}, 32'(addr_col), 32'(exp_col(e[15], e[14:12], e[8:0], i)));
                chk("R5 last position", 32'(addr_last), 32'(i == n - 1));
                chk("R9 bank carry", 32'(addr_bank), 32'(e[11:10]));
                chk("R9 write carry", 32'(addr_write), 32'(e[9]));
                chk("R9 bank one-hot", 32'(bank_active), 32'(4'b0001 << e[11:10]));
                if (i < n - 1) tick();
            end
            tick();
            chk("R5 valid drops after last", 32'(addr_valid), 0);
            chk("R9 one-hot clears", 32'(bank_active), 0);
        end

        // R4 full page: wrap 511 -> 0, never last, then stop (R6).
        mode_set(1'b0, 3'b111);
        issue(RD, 2'd3, 9'd508);
        for (int i = 0; i < 520; i++) begin
            chk("R4 full page col", 32'(addr_col), 32'((508 + i) % 512));
            chk("R4 full page no last", 32'(addr_last), 0);
            chk("R4 full page valid", 32'(addr_valid), 1);
            if (i < 519) tick();
        end
        issue(STP, 2'd0, 9'd0);
        chk("R6 stop ends full page", 32'(addr_valid), 0);

        // R6 stop in the middle of a length-8 burst.
        mode_set(1'b0, 3'b011);
        issue(WR, 2'd2, 9'd16);
        tick(); tick();
        chk("R6 before stop col", 32'(addr_col), 18);
        issue(STP, 2'd0, 9'd0);
        chk("R6 stop mid burst", 32'(addr_valid), 0);
        tick();
        chk("R6 stays idle", 32'(addr_valid), 0);

        // R7 replacement mid burst and on the last beat.
        issue(RD, 2'd0, 9'd0);
        tick();
        chk("R7 old beat", 32'(addr_col), 1);
        issue(WR, 2'd2, 9'h40);
        chk("R7 replaced col", 32'(addr_col), 32'h40);
        chk("R7 replaced bank", 32'(addr_bank), 2);
        chk("R7 replaced write", 32'(addr_write), 1);
        chk("R7 no gap", 32'(addr_valid), 1);
        tick();
        chk("R7 new sequence continues", 32'(addr_col), 32'h41);
        mode_set(1'b0, 3'b001);
        issue(RD, 2'd1, 9'd4);
        tick();
        chk("R7 at last beat", 32'(addr_last), 1);
        issue(RD, 2'd3, 9'd7);
        chk("R7 back-to-back valid", 32'(addr_valid), 1);
        chk("R7 back-to-back col", 32'(addr_col), 7);
        chk("R7 back-to-back not last", 32'(addr_last), 0);
        tick();
        chk("R7 second burst wraps", 32'(addr_col), 6);
        tick();

        // R8 refused settings keep the old mode.
        mode_set(1'b0, 3'b010);
        chk("R8 legal no err", 32'(mode_err), 0);
        mode_set(1'b1, 3'b111);
        chk("R8 interleave full page err", 32'(mode_err), 1);
        tick();
        chk("R8 err one cycle", 32'(mode_err), 0);
        mode_set(1'b0, 3'b101);
        chk("R8 bad code err", 32'(mode_err), 1);
        issue(RD, 2'd1, 9'd6);
        chk("R8 err cleared", 32'(mode_err), 0);
        tick(); tick();
        chk("R8 kept length 4 seq col", 32'(addr_col), 4);
        tick();
        chk("R8 kept length 4 last", 32'(addr_last), 1);
        tick();

        // R10 mode write on the same edge as a command.
        mode_set(1'b0, 3'b001);
        mode_wr = 1'b1; mode_ilv = 1'b0; mode_len = 3'b011;
        cmd_op = RD; cmd_bank = 2'd0; cmd_col = 9'd0;
        tick();
        mode_wr = 1'b0; cmd_op = NOP;
        chk("R10 start col", 32'(addr_col), 0);
        tick();
        chk("R10 old length last", 32'(addr_last), 1);
        tick();
        chk("R10 old length ended", 32'(addr_valid), 0);
        issue(RD, 2'd0, 9'd0);
        for (int i = 0; i < 7; i++) tick();
        chk("R10 new length last", 32'(addr_last), 1);
        chk("R10 new length col", 32'(addr_col), 7);
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule